// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fixed reference clock into the timing pulses a UART needs. It produces an oversample tick at the reference rate divided by a 16-bit integer divisor plus a fraction in sixteenths. It also produces a baud tick once per serial bit. The fractional part is spread over time by a 4-bit phase accumulator. In each divide period where the accumulator carries, the period is stretched by one reference cycle, so any run of 16 consecutive periods holds exactly `frac` extra cycles.

Software reaches the block through a byte-wide register write port with four addresses. Address 0 holds the low divisor byte and address 1 the high divisor byte. Address 2 holds the fraction in bits 3:0 and the rate select in bits 5:4; bits 7:6 of that byte are reserved. Address 3 holds the enhanced-mode control, whose bit 4 unlocks writes to address 2. The rate select sets 16, 8 or 4 oversample ticks per baud tick. A read port with its own address returns the stored value of any register.

The divide engine is a three-state machine. HALT is the idle state and holds while the divisor is zero. COUNT counts reference cycles up to the integer divisor. PAD is the single inserted cycle. The transitions are:
- restart: from any state to COUNT, on an accepted divisor or rate write.
- zero-divisor: COUNT to HALT.
- fire: COUNT stays in COUNT at the last count, when there is no carry.
- stretch: COUNT to PAD at the last count, when there is a carry.
- pad-fire: PAD to COUNT.

An oversample tick is issued on every fire and on every pad-fire.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor, fraction, rate select and enhanced-mode bit are all zero, every register reads back as 0x00, and neither tick asserts.
- R2: With divisor D = {high byte, low byte} ≥ 1 and fraction 0, os_tick pulses every D reference cycles. The first pulse is visible D cycles after the clock edge that accepted the last register write.
- R3: With fraction F, the accumulator starts at 0 and adds F at every tick. Divide period k lasts D cycles plus one extra cycle when the accumulator value before that tick plus F reaches 16. The first period therefore never carries.
- R4: While the integer divisor is zero, no os_tick and no baud_tick is produced.
- R5: A divisor of one with fraction zero gives os_tick on every reference cycle.
- R6: baud_tick asserts together with every Nth os_tick counted from restart. N is 16 for rate bits 5:4 = 00, 8 for 01, and 4 for 10 or 11.
- R7: After reset the ratio is 16 without any write to address 2.
- R8: A write to address 2 while bit 4 of address 3 is clear is ignored. It leaves the readback, the fraction, the rate and the tick timing unchanged, and it does not restart the counters.
- R9: Bits 7:6 of address 2 read back as zero whatever was written, and they have no effect on the ticks.
- R10: Every accepted write to address 0, 1 or 2 restarts the divide counter, the accumulator and the oversample counter. The next tick comes one full new period after the write edge.
- R11: os_tick and baud_tick are registered single-cycle pulses. With D ≥ 2 no two os_ticks are adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low divisor, 1 high divisor, 2 fraction/rate, 3 enhanced control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Stored value of the addressed register |
| os_tick | output | 1 | Oversample tick, one cycle wide |
| baud_tick | output | 1 | Bit tick, one cycle wide, coincident with an os_tick |

## Verification
Several internal faults show up directly at the tick outputs:
- A wrong accumulator value moves the first stretched period, so an os_tick lands one cycle early or late within at most 16 periods after a restart.
- A miscounting oversample counter misplaces the first baud_tick, at most 16 os_ticks after the write.
- A lost or spurious restart shifts the whole tick train relative to the write edge on the very first tick.

The bench compares each cycle against a model of the expected train, so a single misplaced pulse is reported at the cycle where it occurs.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_COUNT,
        ST_PAD
    } div_state_t;

    typedef enum logic [1:0] {
        RATE_X16,
        RATE_X8,
        RATE_X4
    } rate_t;

    localparam logic [1:0] ADDR_DIV_LO = 2'd0;
    localparam logic [1:0] ADDR_DIV_HI = 2'd1;
    localparam logic [1:0] ADDR_FRAC   = 2'd2;
    localparam logic [1:0] ADDR_ENH    = 2'd3;

    // Bit 1 of the select wins; bit 0 only matters when bit 1 is clear.
    function automatic rate_t decode_rate(input logic [1:0] sel);
        if (sel[1]) begin
            return RATE_X4;
        end
        if (sel[0]) begin
            return RATE_X8;
        end
        return RATE_X16;
    endfunction

endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FRAC_W  = 4,
    parameter int ENH_BIT = 4,
    localparam int DIV_W  = 2 * BYTE_W,
    localparam int RSV_W  = BYTE_W - FRAC_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output rate_t             rate_q,
    output logic              enh_q,
    output logic              restart
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic [1:0]        rsel_q;
    logic              frac_ok;
    logic [BYTE_W-1:0] enh_view;
    logic [BYTE_W-1:0] frac_view;

    // The fraction/rate byte is locked unless the enhanced bit is set.
    assign frac_ok = wr_en && (wr_addr == ADDR_FRAC) && enh_q;
    assign restart = (wr_en && ((wr_addr == ADDR_DIV_LO) || (wr_addr == ADDR_DIV_HI))) || frac_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            frac_q <= '0;
            rsel_q <= '0;
            enh_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_DIV_LO: lo_q <= wr_data;
                ADDR_DIV_HI: hi_q <= wr_data;
                ADDR_FRAC: begin
                    if (enh_q) begin
                        frac_q <= wr_data[FRAC_W-1:0];
                        rsel_q <= wr_data[FRAC_W+1:FRAC_W];
                    end
                end
                ADDR_ENH:    enh_q <= wr_data[ENH_BIT];
                default:     ;
            endcase
        end
    end

    assign div_q  = {hi_q, lo_q};
    assign rate_q = decode_rate(rsel_q);

    always_comb begin
        enh_view          = '0;
        enh_view[ENH_BIT] = enh_q;
    end

    // Reserved upper bits are never stored and read as zero.
    assign frac_view = {{RSV_W{1'b0}}, rsel_q, frac_q};

    always_comb begin
        unique case (rd_addr)
            ADDR_DIV_LO: rd_data = lo_q;
            ADDR_DIV_HI: rd_data = hi_q;
            ADDR_FRAC:   rd_data = frac_view;
            ADDR_ENH:    rd_data = enh_view;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fbg_div_fsm.sv
`timescale 1ns/1ps
module fbg_div_fsm
    import fbg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [FRAC_W-1:0] frac_q,
    output logic              fire,
    output logic              os_tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    div_state_t        state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d;
    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic              last;

    assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};
    assign carry   = acc_sum[FRAC_W];
    assign last    = (cnt_q == div_q - ONE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        fire    = 1'b0;
        if (restart) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
            acc_d   = '0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                ST_COUNT: begin
                    if (div_q == '0) begin
                        state_d = ST_HALT;
                        cnt_d   = '0;
                    end else if (last) begin
                        cnt_d = '0;
                        if (carry) begin
                            state_d = ST_PAD;
                        end else begin
                            fire  = 1'b1;
                            acc_d = acc_sum[FRAC_W-1:0];
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_PAD: begin
                    fire    = 1'b1;
                    acc_d   = acc_sum[FRAC_W-1:0];
                    state_d = ST_COUNT;
                end
                default: begin
                    state_d = ST_HALT;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_tick <= 1'b0;
        end else begin
            os_tick <= fire;
        end
    end

endmodule

// File: rtl/fbg_os_count.sv
`timescale 1ns/1ps
module fbg_os_count
    import fbg_pkg::*;
#(
    parameter int OS_CNT_W = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  fire,
    input  rate_t rate_q,
    output logic  baud_tick
);

    logic [OS_CNT_W-1:0] os_cnt_q;
    logic [OS_CNT_W-1:0] lim;

    always_comb begin
        unique case (rate_q)
            RATE_X16: lim = OS_CNT_W'(15);
            RATE_X8:  lim = OS_CNT_W'(7);
            RATE_X4:  lim = OS_CNT_W'(3);
            default:  lim = OS_CNT_W'(15);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt_q  <= '0;
            baud_tick <= 1'b0;
        end else if (restart) begin
            os_cnt_q  <= '0;
            baud_tick <= 1'b0;
        end else if (fire) begin
            if (os_cnt_q == lim) begin
                os_cnt_q  <= '0;
                baud_tick <= 1'b1;
            end else begin
                os_cnt_q  <= os_cnt_q + 1'b1;
                baud_tick <= 1'b0;
            end
        end else begin
            baud_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int FRAC_W   = 4,
    parameter int ENH_BIT  = 4,
    parameter int OS_CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              os_tick,
    output logic              baud_tick
);

    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    rate_t             rate_q;
    logic              enh_q;
    logic              restart;
    logic              fire;

    fbg_regs #(
        .BYTE_W (BYTE_W),
        .FRAC_W (FRAC_W),
        .ENH_BIT(ENH_BIT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .div_q  (div_q),
        .frac_q (frac_q),
        .rate_q (rate_q),
        .enh_q  (enh_q),
        .restart(restart)
    );

    fbg_div_fsm #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .div_q  (div_q),
        .frac_q (frac_q),
        .fire   (fire),
        .os_tick(os_tick)
    );

    fbg_os_count #(
        .OS_CNT_W(OS_CNT_W)
    ) u_os (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .fire     (fire),
        .rate_q   (rate_q),
        .baud_tick(baud_tick)
    );

endmodule

// File: rtl/fbg_checker.sv
`timescale 1ns/1ps
module fbg_checker
    import fbg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    localparam int DIV_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [1:0]        rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic              enh_q,
    input logic              restart,
    input logic [DIV_W-1:0]  div_q,
    input logic [FRAC_W-1:0] frac_q,
    input rate_t             rate_q,
    input logic              os_tick,
    input logic              baud_tick
);

    logic [7:0] seen_q;
    logic [7:0] want_m1;

    always_comb begin
        unique case (rate_q)
            RATE_X8: want_m1 = 8'd7;
            RATE_X4: want_m1 = 8'd3;
            default: want_m1 = 8'd15;
        endcase
    end

    // Counts observed os ticks since the last restart or baud tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (restart) begin
            seen_q <= '0;
        end else if (os_tick) begin
            seen_q <= baud_tick ? 8'd0 : seen_q + 8'd1;
        end
    end

    p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> !os_tick);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && (div_q > DIV_W'(1))) |=> !os_tick);

    p_baud_with_os_r6: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> os_tick);

    p_baud_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (seen_q == want_m1));

    p_locked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_FRAC) && !enh_q) |-> !restart ##1 ($stable(frac_q) && $stable(rate_q)));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_FRAC) |-> (rd_data[BYTE_W-1:FRAC_W+2] == '0));

    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!os_tick && !baud_tick));

endmodule

bind frac_baud_gen fbg_checker #(
    .BYTE_W(BYTE_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .enh_q    (enh_q),
    .restart  (restart),
    .div_q    (div_q),
    .frac_q   (frac_q),
    .rate_q   (rate_q),
    .os_tick  (os_tick),
    .baud_tick(baud_tick)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       os_tick;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .os_tick  (os_tick),
        .baud_tick(baud_tick)
    );

    function automatic int ratio_of(input int code);
        if (code >= 2) return 4;
        if (code == 1) return 8;
        return 16;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the accepting edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data == 8'(exp), req, $sformatf("readback addr %0d", a), rd_data, exp);
    endtask

    // Model of the tick train after a restart at edge t=0: period k lasts div plus
    // one when accumulator (before the tick) + frac reaches 16; baud every ratio-th tick.
    task automatic run_check(input string req, input int div, input int frac, input int ratio, input int len);
        int acc    = 0;
        int ntick  = 0;
        int next_t = (div == 0) ? -1 : div;
        int bad    = 0;
        int bad_t  = 0;
        int bad_a  = 0;
        int bad_e  = 0;
        for (int t = 1; t <= len; t++) begin
            bit exp_os;
            bit exp_b;
            @(negedge clk);
            exp_os = (t == next_t);
            exp_b  = 1'b0;
            if (exp_os) begin
                ntick++;
                exp_b  = ((ntick % ratio) == 0);
                acc    = (acc + frac) % 16;
                next_t = t + div + (((acc + frac) >= 16) ? 1 : 0);
            end
            if ((os_tick !== exp_os) || (baud_tick !== exp_b)) begin
                if (bad == 0) begin
                    bad_t = t;
                    bad_a = {30'd0, os_tick, baud_tick};
                    bad_e = {30'd0, exp_os, exp_b};
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("tick pair {os,baud} at cycle %0d (div %0d frac %0d ratio %0d)",
              bad_t, div, frac, ratio), bad_a, bad_e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        check(os_tick == 1'b0 && baud_tick == 1'b0, "R1", "ticks in reset", {os_tick, baud_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset readback of every register
        rd_chk(2'd0, 0, "R1");
        rd_chk(2'd1, 0, "R1");
        rd_chk(2'd2, 0, "R1");
        rd_chk(2'd3, 0, "R1");
        @(negedge clk);
        // R4: zero divisor after reset gives nothing
        run_check("R4", 0, 0, 16, 60);

        // R7: only the low divisor written, ratio still 16
        wr(2'd0, 8'd3);
        run_check("R7", 3, 0, 16, 3 * 16 * 2 + 4);

        // R2: integer divisor, enhanced mode on
        wr(2'd3, 8'h10);
        rd_chk(2'd3, 8'h10, "R8");
        @(negedge clk);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd5);
        wr(2'd2, 8'h00);
        run_check("R2", 5, 0, 16, 5 * 16 * 2 + 4);

        // R5: divisor 1 with rate 4x
        wr(2'd0, 8'd1);
        wr(2'd2, 8'h20);
        run_check("R5", 1, 0, 4, 40);

        // R3: fractions
        wr(2'd0, 8'd3);
        wr(2'd2, 8'h18);
        run_check("R3", 3, 8, 8, 4 * 8 * 3 + 4);
        wr(2'd0, 8'd2);
        wr(2'd2, 8'h0F);
        run_check("R3", 2, 15, 16, 3 * 16 * 2 + 4);
        wr(2'd0, 8'd1);
        wr(2'd2, 8'h21);
        run_check("R3", 1, 1, 4, 200);

        // R6: rate code 11 behaves like 10; R11 with divisor 2
        wr(2'd0, 8'd2);
        wr(2'd2, 8'h30);
        run_check("R6", 2, 0, 4, 60);
        wr(2'd2, 8'h10);
        run_check("R11", 2, 0, 8, 60);

        // R9: reserved bits dropped
        wr(2'd0, 8'd3);
        wr(2'd2, 8'hC5);
        rd_chk(2'd2, 8'h05, "R9");
        @(negedge clk);
        wr(2'd0, 8'd3);
        run_check("R9", 3, 5, 16, 4 * 16 * 2 + 4);

        // R8: locked write ignored
        wr(2'd3, 8'h00);
        rd_chk(2'd3, 0, "R8");
        @(negedge clk);
        wr(2'd2, 8'h2A);
        rd_chk(2'd2, 8'h05, "R8");
        @(negedge clk);
        wr(2'd0, 8'd4);
        run_check("R8", 4, 5, 16, 5 * 16 * 2 + 4);

        // R10: restart mid-period
        wr(2'd0, 8'd10);
        repeat (4) @(negedge clk);
        wr(2'd1, 8'd0);
        run_check("R10", 10, 5, 16, 11 * 16 + 4);

        // R2: high byte in use
        wr(2'd3, 8'h10);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'd0);
        rd_chk(2'd1, 1, "R2");
        @(negedge clk);
        wr(2'd2, 8'h20);
        run_check("R2", 256, 0, 4, 256 * 5 + 4);

        // R4: divisor back to zero
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd0);
        run_check("R4", 0, 0, 4, 80);

        // R3/R6: random divisor, fraction and rate
        for (int i = 0; i < 20; i++) begin
            int d  = $urandom_range(1, 40);
            int f  = $urandom_range(0, 15);
            int rc = $urandom_range(0, 3);
            wr(2'd1, 8'd0);
            wr(2'd0, 8'(d));
            wr(2'd2, 8'((rc << 4) | f));
            run_check("R3", d, f, ratio_of(rc), (d + 1) * ratio_of(rc) * 2 + 4);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule